// File: doc/BRIEF.md
# Serial Bitstream Configuration Loader

This block programs a target programmable device through its one-bit slave serial configuration port. A host pulses `start` with the number of image bytes on `byte_count`. The image then arrives on a valid/ready byte stream. The loader resets the target with its program line and follows the target's init line through a two-step handshake. It then shifts each byte out most-significant bit first on `cfg_dout`, together with a configuration clock that it generates itself. After the last byte it keeps clocking with the data line held high until the target reports completion.

Throughout the load the block watches the target's init and done lines. It aborts on a readiness timeout, on a checksum error reported mid-stream, or when completion never arrives. It reports the outcome as sticky done or error flags with a cause code. The clock half-period and the timeout length are parameters counted in system clock cycles.

Top module: `cfg_serial_loader`

## Requirements
- R1: A `start` pulse seen while idle raises `busy` and `cfg_prog` on the next cycle, and `cfg_prog` stays high until `cfg_init` is seen high.
- R2: Once `cfg_prog` falls, no configuration clock edge is produced and `in_ready` stays low until `cfg_init` has been seen low.
- R3: If `cfg_init` does not go high within WAIT_CYCLES cycles of `cfg_prog` rising, the load ends with `err` high and `err_cause` = 1.
- R4: If `cfg_init` does not go low within WAIT_CYCLES cycles of `cfg_prog` falling, the load ends with `err` high and `err_cause` = 2.
- R5: Each accepted byte is sent as 8 bits, most-significant first. For each bit, `cfg_cclk` is held low for HALF_CYCLES cycles with the bit already on `cfg_dout`, then held high for HALF_CYCLES cycles. Rising edges inside one byte are therefore 2*HALF_CYCLES cycles apart.
- R6: Before each byte, and again after the last byte, `cfg_init` high while `cfg_done` is low aborts the load with `err_cause` = 3. No further byte is accepted. This check wins over the end-of-image step.
- R7: After `byte_count` bytes, `cfg_dout` is held at 1 and `cfg_cclk` keeps pulsing until `cfg_done` is high. The load then ends with `done` high and `err_cause` = 0.
- R8: If `cfg_done` is not high within WAIT_CYCLES cycles of the trailing clock phase starting, the load ends with `err_cause` = 4.
- R9: `done`, `err` and `err_cause` hold their values until the next accepted `start`, which clears them. `done` and `err` are never high together, and `err` is high exactly when `err_cause` is nonzero.
- R10: A `start` pulse while `busy` is high has no effect: the running load keeps its byte count and finishes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a load (taken only when idle) |
| byte_count | input | CNT_W | Number of image bytes, sampled at start |
| in_data | input | 8 | Image byte |
| in_valid | input | 1 | Image byte valid |
| in_ready | output | 1 | Loader takes the byte this cycle |
| cfg_prog | output | 1 | Program request to target, active high |
| cfg_init | input | 1 | Target init line, high = active |
| cfg_done | input | 1 | Target done line, high = configured |
| cfg_cclk | output | 1 | Generated configuration clock |
| cfg_dout | output | 1 | Serial configuration data |
| busy | output | 1 | Load in progress |
| done | output | 1 | Last load succeeded |
| err | output | 1 | Last load failed |
| err_cause | output | 3 | 0 none, 1 init-set timeout, 2 init-clear timeout, 3 checksum error, 4 done timeout |

## Verification
The two checks that can fall in the same cycle are the checksum test and the end-of-image decision. Both are made in the step that follows the last bit of the final byte. The bench provokes this by having its target model raise init right after the final rising clock edge, with done held low. It then requires cause 3 instead of the trailing clock phase and a later done timeout. The mid-stream case and the normal case, where the image ends with init low, cover each side of that priority on its own.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PROG,
        ST_RELEASE,
        ST_FETCH,
        ST_BIT_LO,
        ST_BIT_HI,
        ST_TAIL_LO,
        ST_TAIL_HI
    } ld_state_e;

    typedef enum logic [2:0] {
        CAUSE_NONE         = 3'd0,
        CAUSE_INIT_SET_TMO = 3'd1,
        CAUSE_INIT_CLR_TMO = 3'd2,
        CAUSE_CRC          = 3'd3,
        CAUSE_DONE_TMO     = 3'd4
    } ld_cause_e;

    typedef struct packed {
        logic      ok;
        logic      fail;
        ld_cause_e cause;
    } ld_status_t;

    function automatic logic in_tail(ld_state_e s);
        return (s == ST_TAIL_LO) || (s == ST_TAIL_HI);
    endfunction

    function automatic logic in_wait(ld_state_e s);
        return (s == ST_PROG) || (s == ST_RELEASE) || in_tail(s);
    endfunction

    function automatic logic clock_high(ld_state_e s);
        return (s == ST_BIT_HI) || (s == ST_TAIL_HI);
    endfunction

endpackage

// File: rtl/cfg_tick_gen.sv
module cfg_tick_gen #(
    parameter int HALF_CYCLES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int W = (HALF_CYCLES > 1) ? $clog2(HALF_CYCLES) : 1;
    localparam logic [W-1:0] LAST = W'(HALF_CYCLES - 1);

    logic [W-1:0] cnt;

    assign tick = run && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || !run || tick) cnt <= '0;
        else                     cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/cfg_wait_timer.sv
module cfg_wait_timer #(
    parameter int LIMIT = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic run,
    output logic expired
);
    localparam int W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [W-1:0] LAST = W'(LIMIT - 1);

    logic [W-1:0] cnt;

    assign expired = (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || clr)           cnt <= '0;
        else if (run && !expired) cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/cfg_bit_shifter.sv
module cfg_bit_shifter #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [WIDTH-1:0] data,
    input  logic             shift,
    output logic             bit_out,
    output logic             last
);
    localparam int IW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
    localparam logic [IW-1:0] TOP = IW'(WIDTH - 1);

    logic [WIDTH-1:0] sh;
    logic [IW-1:0]    idx;

    assign bit_out = sh[WIDTH-1];
    assign last    = (idx == TOP);

    always_ff @(posedge clk) begin
        if (rst) begin
            sh  <= '0;
            idx <= '0;
        end else if (load) begin
            sh  <= data;
            idx <= '0;
        end else if (shift) begin
            sh  <= {sh[WIDTH-2:0], 1'b0};
            idx <= idx + 1'b1;
        end
    end
endmodule

// File: rtl/cfg_serial_loader.sv
module cfg_serial_loader
    import cfg_loader_pkg::*;
#(
    parameter int HALF_CYCLES = 2,
    parameter int WAIT_CYCLES = 1250000,
    parameter int CNT_W       = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CNT_W-1:0] byte_count,
    input  logic [7:0]       in_data,
    input  logic             in_valid,
    output logic             in_ready,
    output logic             cfg_prog,
    input  logic             cfg_init,
    input  logic             cfg_done,
    output logic             cfg_cclk,
    output logic             cfg_dout,
    output logic             busy,
    output logic             done,
    output logic             err,
    output logic [2:0]       err_cause
);
    localparam int HALF_EFF = (HALF_CYCLES < 1) ? 1 : HALF_CYCLES;

    ld_state_e        state, nxt;
    ld_status_t       stat, stat_nxt;
    logic [CNT_W-1:0] left;
    logic             tick, expired, tmr_clr;
    logic             ser_bit, ser_last, ser_load, ser_shift;
    logic             crc_hit, take;

    cfg_tick_gen #(.HALF_CYCLES(HALF_EFF)) u_tick (
        .clk(clk), .rst(rst),
        .run(state == ST_BIT_LO || state == ST_BIT_HI || in_tail(state)),
        .tick(tick)
    );

    cfg_wait_timer #(.LIMIT(WAIT_CYCLES)) u_wait (
        .clk(clk), .rst(rst), .clr(tmr_clr), .run(in_wait(state)),
        .expired(expired)
    );

    cfg_bit_shifter #(.WIDTH(8)) u_shift (
        .clk(clk), .rst(rst), .load(ser_load), .data(in_data),
        .shift(ser_shift), .bit_out(ser_bit), .last(ser_last)
    );

    assign crc_hit   = cfg_init && !cfg_done;
    assign in_ready  = (state == ST_FETCH) && !crc_hit && (left != '0);
    assign take      = in_ready && in_valid;
    assign ser_load  = take;
    assign ser_shift = (state == ST_BIT_HI) && tick && !ser_last;
    assign tmr_clr   = (nxt != state) && !(in_tail(nxt) && in_tail(state));

    always_comb begin
        nxt      = state;
        stat_nxt = stat;
        unique case (state)
            ST_IDLE: if (start) begin
                nxt      = ST_PROG;
                stat_nxt = '{ok: 1'b0, fail: 1'b0, cause: CAUSE_NONE};
            end
            ST_PROG: begin
                if (cfg_init) nxt = ST_RELEASE;
                else if (expired) begin
                    nxt      = ST_IDLE;
                    stat_nxt = '{ok: 1'b0, fail: 1'b1, cause: CAUSE_INIT_SET_TMO};
                end
            end
            ST_RELEASE: begin
                if (!cfg_init) nxt = ST_FETCH;
                else if (expired) begin
                    nxt      = ST_IDLE;
                    stat_nxt = '{ok: 1'b0, fail: 1'b1, cause: CAUSE_INIT_CLR_TMO};
                end
            end
            ST_FETCH: begin
                if (crc_hit) begin
                    nxt      = ST_IDLE;
                    stat_nxt = '{ok: 1'b0, fail: 1'b1, cause: CAUSE_CRC};
                end else if (left == '0) nxt = ST_TAIL_LO;
                else if (take)           nxt = ST_BIT_LO;
            end
            ST_BIT_LO: if (tick) nxt = ST_BIT_HI;
            ST_BIT_HI: if (tick) nxt = ser_last ? ST_FETCH : ST_BIT_LO;
            ST_TAIL_LO, ST_TAIL_HI: begin
                if (cfg_done) begin
                    nxt      = ST_IDLE;
                    stat_nxt = '{ok: 1'b1, fail: 1'b0, cause: CAUSE_NONE};
                end else if (expired) begin
                    nxt      = ST_IDLE;
                    stat_nxt = '{ok: 1'b0, fail: 1'b1, cause: CAUSE_DONE_TMO};
                end else if (tick) begin
                    nxt = (state == ST_TAIL_LO) ? ST_TAIL_HI : ST_TAIL_LO;
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            stat  <= '{ok: 1'b0, fail: 1'b0, cause: CAUSE_NONE};
            left  <= '0;
        end else begin
            state <= nxt;
            stat  <= stat_nxt;
            if (state == ST_IDLE && start) left <= byte_count;
            else if (take)                 left <= left - 1'b1;
        end
    end

    assign busy      = (state != ST_IDLE);
    assign cfg_prog  = (state == ST_PROG);
    assign cfg_cclk  = clock_high(state);
    assign cfg_dout  = in_tail(state) ? 1'b1 :
                       ((state == ST_BIT_LO || state == ST_BIT_HI) ? ser_bit : 1'b0);
    assign done      = stat.ok;
    assign err       = stat.fail;
    assign err_cause = stat.cause;
endmodule

// File: rtl/cfg_serial_loader_chk.sv
module cfg_serial_loader_chk (
    input logic       clk,
    input logic       rst,
    input logic       start,
    input logic       in_ready,
    input logic       cfg_prog,
    input logic       cfg_cclk,
    input logic       cfg_dout,
    input logic       busy,
    input logic       done,
    input logic       err,
    input logic [2:0] err_cause
);
    // R2
    prog_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_prog |-> (!cfg_cclk && !in_ready));

    // R5
    data_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_cclk && $past(cfg_cclk)) |-> $stable(cfg_dout));

    // R5
    fetch_clk_low_chk: assert property (@(posedge clk) disable iff (rst)
        in_ready |-> !cfg_cclk);

    // R9
    status_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(done && err));

    // R9
    cause_match_chk: assert property (@(posedge clk) disable iff (rst)
        err == (err_cause != 3'd0));

    // R1
    start_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> ($past(start) && cfg_prog));

    // R10
    busy_start_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && start && !cfg_prog) |=> !cfg_prog);
endmodule

bind cfg_serial_loader cfg_serial_loader_chk u_chk (
    .clk(clk), .rst(rst), .start(start), .in_ready(in_ready),
    .cfg_prog(cfg_prog), .cfg_cclk(cfg_cclk), .cfg_dout(cfg_dout),
    .busy(busy), .done(done), .err(err), .err_cause(err_cause)
);

// File: tb/cfg_serial_loader_tb.sv
module cfg_serial_loader_tb;
    localparam int HALF  = 3;
    localparam int WAITC = 200;
    localparam int CW    = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [CW-1:0] byte_count = '0;
    logic [7:0]    in_data;
    logic          in_valid, in_ready;
    logic          cfg_prog, cfg_cclk, cfg_dout;
    logic          busy, done, err;
    logic [2:0]    err_cause;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    logic [7:0] src [0:7];
    int         src_n = 0;
    int         src_idx = 0;
    logic       feed_en = 1'b0;

    int    cfg_no_init = 0, cfg_stuck = 0, cfg_crc_bits = 0, cfg_done_bits = 0;
    logic  init_m = 1'b0, done_m = 1'b0, cclk_q = 1'b0;
    int    dly = 0, rx_bits = 0, t0 = 0, t1 = 0;
    logic [63:0] rx_shift = '0;

    always #4 clk = ~clk;

    cfg_serial_loader #(.HALF_CYCLES(HALF), .WAIT_CYCLES(WAITC), .CNT_W(CW)) u_dut (
        .clk(clk), .rst(rst), .start(start), .byte_count(byte_count),
        .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
        .cfg_prog(cfg_prog), .cfg_init(init_m), .cfg_done(done_m),
        .cfg_cclk(cfg_cclk), .cfg_dout(cfg_dout), .busy(busy),
        .done(done), .err(err), .err_cause(err_cause)
    );

    assign in_valid = feed_en && (src_idx < src_n);
    assign in_data  = src[src_idx[2:0]];

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (start && !busy)            src_idx <= 0;
        else if (in_valid && in_ready) src_idx <= src_idx + 1;
    end

    // target device model
    always @(posedge clk) begin
        cclk_q <= cfg_cclk;
        if (cfg_prog) begin
            init_m  <= (cfg_no_init == 0);
            dly     <= 0;
            rx_bits <= 0;
            done_m  <= 1'b0;
        end else begin
            if (cfg_crc_bits != 0 && rx_bits >= cfg_crc_bits) init_m <= 1'b1;
            else if (init_m && cfg_stuck == 0) begin
                if (dly == 4) init_m <= 1'b0;
                dly <= dly + 1;
            end
            if (cfg_cclk && !cclk_q) begin
                rx_shift <= {rx_shift[62:0], cfg_dout};
                rx_bits  <= rx_bits + 1;
                if (rx_bits == 0) t0 <= cyc;
                if (rx_bits == 1) t1 <= cyc;
            end
            if (cfg_done_bits != 0 && rx_bits >= cfg_done_bits) done_m <= 1'b1;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic setup(input int nb, input int no_init, input int stuck,
                         input int crc, input int dn);
        cfg_no_init   = no_init;
        cfg_stuck     = stuck;
        cfg_crc_bits  = crc;
        cfg_done_bits = dn;
        src_n         = nb;
        feed_en       = 1'b1;
    endtask

    task automatic kick(input int nb);
        @(negedge clk);
        byte_count = CW'(nb);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_idle();
        int guard = 0;
        while (busy && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
        check(!busy, "watchdog-load", busy, 0);
    endtask

    function automatic int rx_byte(input int i);
        return int'(rx_shift[(rx_bits - 1 - 8*i) -: 8]);
    endfunction

    function automatic bit tail_ones(input int nb);
        for (int k = 0; k < rx_bits - 8*nb && k < 64; k++)
            if (!rx_shift[k]) return 1'b0;
        return 1'b1;
    endfunction

    task automatic t_reset();
        check(!busy && !cfg_prog && !cfg_cclk && !in_ready, "R1 reset idle",
              {busy, cfg_prog, cfg_cclk, in_ready}, 0);
        check(!done && !err && err_cause == 0, "R9 reset status",
              {done, err, err_cause}, 0);
    endtask

    task automatic t_normal();
        src[0] = 8'hA5; src[1] = 8'h3C; src[2] = 8'hF0;
        setup(3, 0, 0, 0, 27);
        kick(3);
        check(busy && cfg_prog, "R1 prog after start", {busy, cfg_prog}, 3);
        check(!done && !err, "R9 status cleared at start", {done, err}, 0);
        wait_idle();
        check(rx_byte(0) == 8'hA5, "R5 byte0", rx_byte(0), 8'hA5);
        check(rx_byte(1) == 8'h3C, "R5 byte1", rx_byte(1), 8'h3C);
        check(rx_byte(2) == 8'hF0, "R5 byte2", rx_byte(2), 8'hF0);
        check(t1 - t0 == 2*HALF, "R5 bit period", t1 - t0, 2*HALF);
        check(done && !err && err_cause == 0, "R7 success", {done, err_cause}, 8);
        check(tail_ones(3), "R7 tail data high", 0, 1);
        repeat (5) @(negedge clk);
        check(done && !busy, "R9 done sticky", done, 1);
    endtask

    task automatic t_ignored_start();
        src[0] = 8'h81; src[1] = 8'h7E; src[2] = 8'h11; src[3] = 8'h22;
        setup(4, 0, 0, 0, 19);
        kick(2);
        repeat (40) @(negedge clk);
        start = 1'b1; byte_count = CW'(4);
        @(negedge clk);
        start = 1'b0;
        wait_idle();
        check(src_idx == 2, "R10 byte count kept", src_idx, 2);
        check(done && rx_byte(1) == 8'h7E, "R10 load finished", rx_byte(1), 8'h7E);
    endtask

    task automatic t_init_set_tmo();
        setup(1, 1, 0, 0, 0);
        src[0] = 8'hFF;
        kick(1);
        wait_idle();
        check(err && err_cause == 1, "R3 init-set timeout", err_cause, 1);
        check(rx_bits == 0, "R3 nothing shifted", rx_bits, 0);
    endtask

    task automatic t_init_clr_tmo();
        setup(1, 0, 1, 0, 0);
        src[0] = 8'hFF;
        kick(1);
        wait_idle();
        check(err && err_cause == 2, "R4 init-clear timeout", err_cause, 2);
        check(rx_bits == 0 && src_idx == 0, "R2 no clocks before init clears",
              rx_bits + src_idx, 0);
    endtask

    task automatic t_crc_mid();
        src[0] = 8'h12; src[1] = 8'h34; src[2] = 8'h56;
        setup(3, 0, 0, 8, 0);
        kick(3);
        wait_idle();
        check(err && err_cause == 3, "R6 crc mid-stream", err_cause, 3);
        check(src_idx == 1 && rx_bits == 8, "R6 stop after crc", src_idx*100 + rx_bits, 108);
    endtask

    task automatic t_crc_last();
        src[0] = 8'h9C; src[1] = 8'h63;
        setup(2, 0, 0, 16, 0);
        kick(2);
        wait_idle();
        check(err_cause == 3, "R6 crc wins over end of image", err_cause, 3);
        check(rx_bits == 16, "R6 no trailing clocks", rx_bits, 16);
    endtask

    task automatic t_done_tmo();
        src[0] = 8'h5A;
        setup(1, 0, 0, 0, 0);
        kick(1);
        wait_idle();
        check(err && err_cause == 4, "R8 done timeout", err_cause, 4);
        check(rx_bits > 8 && tail_ones(1), "R7 tail clocks with data high", rx_bits, 9);
    endtask

    task automatic t_recover();
        src[0] = 8'hC3;
        setup(1, 0, 0, 0, 10);
        kick(1);
        check(!err && err_cause == 0, "R9 error cleared by start", err_cause, 0);
        wait_idle();
        check(done && !err && rx_byte(0) == 8'hC3, "R9 load after error", rx_byte(0), 8'hC3);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_normal();
        t_ignored_start();
        t_init_set_tmo();
        t_init_clr_tmo();
        t_crc_mid();
        t_crc_last();
        t_done_tmo();
        t_recover();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #1000000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule